// File: doc/BRIEF.md
# Saturating multiply-accumulate unit

This unit sits beside the integer pipeline of a 32-bit processor. It keeps a 64-bit signed accumulator, exposed as a high word and a low word, and adds the product of two operands to it each time the pipeline issues a strobe. The operation select picks one of two products. The long product multiplies both full 32-bit operands as signed numbers. The word product multiplies only the low 16 bits of each operand, each taken as signed.

A saturation-mode input controls how the sum is written back, and each product has its own rule. In long mode, the upper bits of the high word are forced to ones or cleared according to the sign of the sum. In word mode, the sum is clamped to the signed 32-bit range, and the high word is set to 1 to show that the clamp acted. Software can also clear the accumulator or load either half directly.

Top module: `mac_sat_unit`

## Requirements
- R1: A synchronous active-high reset sets both accumulator halves to zero.
- R2: With op_sel=0 (long), the strobe adds the full 64-bit signed product of the two signed 32-bit operands. With sat_en=0, the 64-bit sum is stored wrapping modulo 2^64.
- R3: With op_sel=1 (word), the strobe adds the product of operand bits 15:0 of each operand, each sign-extended. Operand bits 31:16 have no effect. With sat_en=0, the sum wraps modulo 2^64.
- R4: In long mode with sat_en=1, a negative 64-bit sum is stored with high-word bits 31:16 forced to one. All other bits are stored as summed.
- R5: In long mode with sat_en=1, a non-negative sum is stored with high-word bits 31:15 cleared. All other bits are stored as summed.
- R6: In word mode with sat_en=1, a sum below -2^31 stores high word 0x00000001 and low word 0x80000000.
- R7: In word mode with sat_en=1, a sum above 2^31-1 stores high word 0x00000001 and low word 0x7FFFFFFF.
- R8: In word mode with sat_en=1, a sum within [-2^31, 2^31-1] is stored as the full 64-bit sum, so the high word is the sign extension of the low word.
- R9: A result appears on the outputs on the first clock edge after the strobe cycle. The accumulator holds its value in any cycle without a strobe, clear or write.
- R10: clr=1 zeroes both halves at the next edge. It takes priority over direct writes and over a strobe in the same cycle.
- R11: wr_hi_en loads wr_data into the high word and wr_lo_en loads it into the low word. Both can be set together. When either write is active, a strobe in that cycle is discarded, and a half that is not written holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Single-cycle operation strobe |
| op_sel | input | 1 | 0 = long product, 1 = word product |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sat_en | input | 1 | Saturating write-back mode |
| clr | input | 1 | Synchronous clear of the accumulator |
| wr_hi_en | input | 1 | Direct write of the high word |
| wr_lo_en | input | 1 | Direct write of the low word |
| wr_data | input | 32 | Data for direct writes |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
The word-mode clamps are the hardest cases to reach. From zero, a single 16x16 product cannot push the sum outside the signed 32-bit range. The bench therefore uses the direct writes to place the accumulator at the range edges (-2^31 and 2^31-1), and then issues small word products that step just past each edge. Long-mode saturation is reached the same way: preloaded high words with mixed upper bits show which bits are forced and which are kept.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int MAC_DATA_W = 32;
    localparam int MAC_ACC_W  = 2 * MAC_DATA_W;

    typedef enum logic {
        MAC_OP_LONG = 1'b0,
        MAC_OP_WORD = 1'b1
    } mac_op_e;

    typedef struct packed {
        logic [MAC_DATA_W-1:0] hi;
        logic [MAC_DATA_W-1:0] lo;
    } mac_acc_t;

    // True when a 64-bit value is representable as a signed 32-bit number.
    function automatic logic fits_half(input logic [MAC_ACC_W-1:0] v);
        logic [MAC_DATA_W:0] top;
        top = v[MAC_ACC_W-1:MAC_DATA_W-1];
        return (&top) || (~|top);
    endfunction

    function automatic mac_acc_t clamp_pos();
        mac_acc_t r;
        r.hi = MAC_DATA_W'(1);
        r.lo = {1'b0, {(MAC_DATA_W-1){1'b1}}};
        return r;
    endfunction

    function automatic mac_acc_t clamp_neg();
        mac_acc_t r;
        r.hi = MAC_DATA_W'(1);
        r.lo = {1'b1, {(MAC_DATA_W-1){1'b0}}};
        return r;
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  mac_op_e                op,
    input  logic [MAC_DATA_W-1:0]  a,
    input  logic [MAC_DATA_W-1:0]  b,
    output logic [MAC_ACC_W-1:0]   prod
);
    localparam int EXT_W = MAC_ACC_W - WORD_W;
    localparam int HEXT  = MAC_ACC_W - MAC_DATA_W;

    logic signed [MAC_ACC_W-1:0] long_a, long_b, word_a, word_b;
    logic signed [MAC_ACC_W-1:0] long_p, word_p;

    generate
        if (WORD_W < MAC_DATA_W) begin : g_word_narrow
            assign word_a = {{EXT_W{a[WORD_W-1]}}, a[WORD_W-1:0]};
            assign word_b = {{EXT_W{b[WORD_W-1]}}, b[WORD_W-1:0]};
        end else begin : g_word_full
            assign word_a = {{HEXT{a[MAC_DATA_W-1]}}, a};
            assign word_b = {{HEXT{b[MAC_DATA_W-1]}}, b};
        end
    endgenerate

    assign long_a = {{HEXT{a[MAC_DATA_W-1]}}, a};
    assign long_b = {{HEXT{b[MAC_DATA_W-1]}}, b};

    assign long_p = long_a * long_b;
    assign word_p = word_a * word_b;

    always_comb begin
        prod = (op == MAC_OP_WORD) ? word_p : long_p;
    end
endmodule

// File: rtl/mac_sat.sv
module mac_sat
    import mac_pkg::*;
(
    input  mac_op_e               op,
    input  logic                  sat_en,
    input  mac_acc_t              acc,
    input  logic [MAC_ACC_W-1:0]  prod,
    output mac_acc_t              result
);
    localparam int SET_LO = MAC_DATA_W / 2;
    localparam int CLR_LO = MAC_DATA_W / 2 - 1;

    logic [MAC_ACC_W-1:0] sum;
    mac_acc_t             raw, long_sat, word_sat;

    assign sum = acc + prod;
    assign raw = sum;

    always_comb begin
        long_sat = raw;
        if (sum[MAC_ACC_W-1]) begin
            long_sat.hi[MAC_DATA_W-1:SET_LO] = '1;
        end else begin
            long_sat.hi[MAC_DATA_W-1:CLR_LO] = '0;
        end
    end

    always_comb begin
        if (fits_half(sum)) begin
            word_sat = raw;
        end else if (sum[MAC_ACC_W-1]) begin
            word_sat = clamp_neg();
        end else begin
            word_sat = clamp_pos();
        end
    end

    always_comb begin
        if (!sat_en) begin
            result = raw;
        end else if (op == MAC_OP_WORD) begin
            result = word_sat;
        end else begin
            result = long_sat;
        end
    end
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg
    import mac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [MAC_DATA_W-1:0] wr_data,
    input  logic                  load,
    input  mac_acc_t              next,
    output mac_acc_t              acc
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (wr_hi || wr_lo) begin
            if (wr_hi) acc.hi <= wr_data;
            if (wr_lo) acc.lo <= wr_data;
        end else if (load) begin
            acc <= next;
        end
    end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  op_valid,
    input  logic                  op_sel,
    input  logic [MAC_DATA_W-1:0] opnd_a,
    input  logic [MAC_DATA_W-1:0] opnd_b,
    input  logic                  sat_en,
    input  logic                  clr,
    input  logic                  wr_hi_en,
    input  logic                  wr_lo_en,
    input  logic [MAC_DATA_W-1:0] wr_data,
    output logic [MAC_DATA_W-1:0] acc_hi,
    output logic [MAC_DATA_W-1:0] acc_lo
);
    localparam int SET_LO = MAC_DATA_W / 2;
    localparam int CLR_LO = MAC_DATA_W / 2 - 1;

    mac_op_e              op;
    logic [MAC_ACC_W-1:0] prod;
    mac_acc_t             acc_q, acc_d;

    assign op = mac_op_e'(op_sel);

    mac_mult #(.WORD_W(WORD_W)) u_mult (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .prod (prod)
    );

    mac_sat u_sat (
        .op     (op),
        .sat_en (sat_en),
        .acc    (acc_q),
        .prod   (prod),
        .result (acc_d)
    );

    mac_acc_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .wr_hi   (wr_hi_en),
        .wr_lo   (wr_lo_en),
        .wr_data (wr_data),
        .load    (op_valid),
        .next    (acc_d),
        .acc     (acc_q)
    );

    assign acc_hi = acc_q.hi;
    assign acc_lo = acc_q.lo;

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (acc_hi == '0 && acc_lo == '0));

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_hi == '0 && acc_lo == '0));

    a_r11_write_hi: assert property (@(posedge clk) disable iff (rst)
        (wr_hi_en && !clr) |=> acc_hi == $past(wr_data));

    a_r11_lo_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_hi_en && !wr_lo_en && !clr) |=> acc_lo == $past(acc_lo));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !clr && !wr_hi_en && !wr_lo_en) |=>
            ($stable(acc_hi) && $stable(acc_lo)));

    a_r8_word_sat_shape: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel && sat_en && !clr && !wr_hi_en && !wr_lo_en) |=>
            (acc_hi == MAC_DATA_W'(1) || acc_hi == {MAC_DATA_W{acc_lo[MAC_DATA_W-1]}}));

    // Covers R5 as well as R4: one of the two masks must be visible.
    a_r4_long_sat_shape: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_sel && sat_en && !clr && !wr_hi_en && !wr_lo_en) |=>
            ((&acc_hi[MAC_DATA_W-1:SET_LO]) || (acc_hi[MAC_DATA_W-1:CLR_LO] == '0)));
endmodule

// File: tb/mac_sat_unit_bench.sv
`timescale 1ns/1ps
module mac_sat_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_sel, sat_en, clr, wr_hi_en, wr_lo_en;
    logic [31:0] opnd_a, opnd_b, wr_data;
    logic [31:0] acc_hi, acc_lo;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t     scb[$];
    logic [63:0] model;

    always #10 clk = ~clk;

    mac_sat_unit u_mac_sat_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_en(sat_en), .clr(clr),
        .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en), .wr_data(wr_data),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    function automatic logic [63:0] calc(input logic [63:0] acc, input bit word,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input bit sat);
        longint p, s;
        logic [63:0] r;
        if (word) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        else      p = longint'($signed(a)) * longint'($signed(b));
        s = longint'(acc) + p;
        r = s;
        if (sat) begin
            if (!word) begin
                if (s < 0) r[63:48] = '1;
                else       r[63:47] = '0;
            end else if (s < -64'sd2147483648) begin
                r = {32'd1, 32'h8000_0000};
            end else if (s > 64'sd2147483647) begin
                r = {32'd1, 32'h7FFF_FFFF};
            end
        end
        return r;
    endfunction

    // Driver: one cycle of stimulus, expected value pushed to the scoreboard.
    task automatic cyc(input bit v, input bit word, input logic [31:0] a,
                       input logic [31:0] b, input bit sat, input bit c,
                       input bit wh, input bit wl, input logic [31:0] wd,
                       input string tag);
        item_t it;
        @(negedge clk);
        op_valid = v; op_sel = word; opnd_a = a; opnd_b = b; sat_en = sat;
        clr = c; wr_hi_en = wh; wr_lo_en = wl; wr_data = wd;
        if (c) model = '0;
        else if (wh || wl) begin
            if (wh) model[63:32] = wd;
            if (wl) model[31:0]  = wd;
        end else if (v) model = calc(model, word, a, b, sat);
        it.exp = model;
        it.tag = tag;
        scb.push_back(it);
    endtask

    task automatic load(input logic [31:0] hi, input logic [31:0] lo);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, hi, "R11 load hi");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, lo, "R11 load lo");
    endtask

    // Monitor: compares after every edge that has an expected item.
    always @(posedge clk) begin
        #2;
        if (scb.size() > 0) begin
            item_t it;
            it = scb.pop_front();
            checks++;
            if ({acc_hi, acc_lo} !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h_%h expected %h_%h", it.tag,
                         acc_hi, acc_lo, it.exp[63:32], it.exp[31:0]);
            end
        end
    end

    initial begin
        item_t it;
        rst = 1'b1; op_valid = 0; op_sel = 0; sat_en = 0; clr = 0;
        wr_hi_en = 0; wr_lo_en = 0; opnd_a = 0; opnd_b = 0; wr_data = 0;
        model = '0;
        @(negedge clk);
        @(negedge clk);
        it.exp = '0; it.tag = "R1 reset";
        scb.push_back(it);
        @(negedge clk);
        rst = 1'b0;

        // R2 long, no saturation, plus wrap at the top of the range
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 32'd5, "R11 lo write");
        cyc(1, 0, 32'hFFFF_FFFD, 32'd7, 0, 0, 0, 0, 0, "R2 long signed");
        cyc(1, 0, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 0, "R2 long min*min");
        load(32'h7FFF_FFFF, 32'hFFFF_FFFF);
        cyc(1, 0, 32'd1, 32'd1, 0, 0, 0, 0, 0, "R2 wrap 2^63");
        // R3 word, upper operand bits ignored
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 clear");
        cyc(1, 1, 32'hABCD_0003, 32'h1234_FFFE, 0, 0, 0, 0, 0, "R3 word -6");
        cyc(1, 1, 32'hFFFF_8000, 32'h0000_8000, 0, 0, 0, 0, 0, "R3 word min*min");
        // R9 hold with busy operand inputs
        cyc(0, 0, 32'h1234_5678, 32'h9ABC_DEF0, 1, 0, 0, 0, 32'hDEAD_BEEF, "R9 hold");
        cyc(0, 1, 32'hFFFF_FFFF, 32'h7FFF_7FFF, 0, 0, 0, 0, 0, "R9 hold 2");
        // R4 / R5 long saturation
        load(32'h8000_1234, 32'h0000_0000);
        cyc(1, 0, 0, 0, 1, 0, 0, 0, 0, "R4 long sat negative");
        load(32'h1234_ABCD, 32'h5555_0000);
        cyc(1, 0, 32'd3, 32'd4, 1, 0, 0, 0, 0, "R5 long sat non-negative");
        cyc(1, 0, 32'hFFFF_FFFF, 32'd1, 1, 0, 0, 0, 0, "R5 long sat small");
        // R6 / R7 / R8 word saturation at the range edges
        load(32'hFFFF_FFFF, 32'h8000_0000);
        cyc(1, 1, 32'd0, 32'd0, 1, 0, 0, 0, 0, "R8 word sat at -2^31");
        cyc(1, 1, 32'd1, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, "R6 word sat below");
        load(32'h0000_0000, 32'h7FFF_FFFF);
        cyc(1, 1, 32'd0, 32'd5, 1, 0, 0, 0, 0, "R8 word sat at 2^31-1");
        cyc(1, 1, 32'd1, 32'd1, 1, 0, 0, 0, 0, "R7 word sat above");
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 clear");
        cyc(1, 1, 32'h0000_7FFF, 32'h0000_7FFF, 1, 0, 0, 0, 0, "R8 in range pos");
        cyc(1, 1, 32'h0000_8000, 32'h0000_7FFF, 1, 0, 0, 0, 0, "R8 in range");
        cyc(1, 1, 32'h0000_8000, 32'h0000_7FFF, 1, 0, 0, 0, 0, "R8 in range neg");
        // R10 priority and R11 override
        cyc(1, 0, 32'd9, 32'd9, 0, 1, 1, 1, 32'hCAFE_F00D, "R10 clear wins");
        load(32'h0000_0011, 32'h0000_0022);
        cyc(1, 0, 32'd100, 32'd100, 0, 0, 1, 0, 32'h0000_0777, "R11 hi write over op");
        cyc(1, 1, 32'd100, 32'd100, 1, 0, 0, 1, 32'h0000_0999, "R11 lo write over op");
        cyc(1, 0, 32'd2, 32'd3, 0, 0, 1, 1, 32'h0000_0042, "R11 both halves");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 final hold");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule